// File: doc/BRIEF.md
# Coherence Request Home-Node Router

This block sits beside a core's coherence engine and decides which core, acting as home node, receives each outgoing coherence request. It takes the request address together with a hit flag from the access-pattern table, which is looked up at the same time. If the address matched a stored pattern, the request leaves as a speculative message. Its destination is picked round-robin over the cores using the page index, so whole pages share a home node. If there was no match, the request leaves as a baseline message. Its destination is picked round-robin using the cache-line index, so consecutive lines spread across the cores.

The destination is the interleaving index reduced modulo the core count. The core count need not be a power of two. The reduction is a combinational restoring-remainder chain, so no divider is needed. The result is held in a single output register behind a valid/ready handshake. A stalled consumer therefore stalls the requester in the same cycle.

Top module: `hnode_router`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `req_ready` is 1.
- R2: A request accepted with `req_pat_hit`=0 is emitted with `out_spec`=0 (baseline). Its `out_core` equals (`req_addr` / LINE_BYTES) mod NUM_CORES, with LINE_BYTES=64.
- R3: A request accepted with `req_pat_hit`=1 is emitted with `out_spec`=1 (speculative). Its `out_core` equals (`req_addr` / PAGE_BYTES) mod NUM_CORES, with PAGE_BYTES defaulting to 4096.
- R4: A request accepted at a clock edge appears on the outputs, with `out_valid`=1, right after that same edge (one-cycle latency).
- R5: While `out_valid`=1 and `out_ready`=0, `req_ready` is 0. In the next cycle `out_valid` stays 1 and `out_core` and `out_spec` are unchanged.
- R6: When `out_ready`=1, `req_ready` is 1 and a new request is accepted every cycle. Back-to-back requests come out in order with no gap.
- R7: Address bits below the line size do not change the destination of a baseline request. Address bits below the page size do not change the destination of a speculative request.
- R8: Whenever `out_valid`=1, `out_core` is below NUM_CORES, including indices that wrap past the core count and addresses with the top bits set.
- R9: A cycle with `req_valid`=0 adds no message. Once the held message is taken, `out_valid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can take a request this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_pat_hit | input | 1 | Pattern-table lookup matched this address |
| out_valid | output | 1 | Routed message present |
| out_ready | input | 1 | Consumer takes the message this cycle |
| out_core | output | $clog2(NUM_CORES) | Destination home-node core ID |
| out_spec | output | 1 | Message type: 0 baseline, 1 speculative |

## Verification
The bench builds the router with six cores, 32-bit addresses, 64-byte lines and 4 KB pages. Six cores is not a power of two, so a low-bit slice would give wrong destinations. Index 6 wrapping to core 0 and the all-ones upper address range are then real tests of the remainder chain. The line and page sizes let a single address sit at the very edge of a line or page. That separates the two granularities directly.

// File: rtl/hnr_pkg.sv
package hnr_pkg;

    typedef enum logic {
        MSG_BASE = 1'b0,
        MSG_SPEC = 1'b1
    } msg_kind_e;

endpackage

// File: rtl/hnr_mod_reduce.sv
// Restoring remainder: value mod DIV, one conditional subtract per input bit.
module hnr_mod_reduce #(
    parameter int IN_W  = 32,
    parameter int DIV   = 6,
    parameter int OUT_W = 3
) (
    input  logic [IN_W-1:0]  value,
    output logic [OUT_W-1:0] rem
);

    localparam logic [OUT_W:0] DIV_V = (OUT_W+1)'(DIV);

    logic [OUT_W:0] acc;

    always_comb begin
        acc = '0;
        for (int i = IN_W - 1; i >= 0; i--) begin
            acc = {acc[OUT_W-1:0], value[i]};
            if (acc >= DIV_V) begin
                acc = acc - DIV_V;
            end
        end
        rem = acc[OUT_W-1:0];
    end

endmodule

// File: rtl/hnr_dest_pick.sv
// Chooses interleave granularity from the pattern hit and reduces to a core ID.
module hnr_dest_pick #(
    parameter int ADDR_W     = 32,
    parameter int NUM_CORES  = 6,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int ID_W       = $clog2(NUM_CORES)
) (
    input  logic                  [ADDR_W-1:0] addr,
    input  logic                               pat_hit,
    output logic                  [ID_W-1:0]   core,
    output hnr_pkg::msg_kind_e                 kind
);

    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] line_idx;
    logic [ADDR_W-1:0] page_idx;
    logic [ID_W-1:0]   line_home;
    logic [ID_W-1:0]   page_home;

    assign line_idx = addr >> LINE_SH;
    assign page_idx = addr >> PAGE_SH;

    hnr_mod_reduce #(.IN_W(ADDR_W), .DIV(NUM_CORES), .OUT_W(ID_W)) line_red_i (
        .value (line_idx),
        .rem   (line_home)
    );

    hnr_mod_reduce #(.IN_W(ADDR_W), .DIV(NUM_CORES), .OUT_W(ID_W)) page_red_i (
        .value (page_idx),
        .rem   (page_home)
    );

    always_comb begin
        if (pat_hit) begin
            core = page_home;
            kind = hnr_pkg::MSG_SPEC;
        end else begin
            core = line_home;
            kind = hnr_pkg::MSG_BASE;
        end
    end

endmodule

// File: rtl/hnode_router.sv
module hnode_router #(
    parameter int ADDR_W     = 32,
    parameter int NUM_CORES  = 6,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    localparam int ID_W      = $clog2(NUM_CORES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_pat_hit,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ID_W-1:0]   out_core,
    output logic              out_spec
);

    typedef struct packed {
        logic               vld;
        logic [ID_W-1:0]    core;
        hnr_pkg::msg_kind_e kind;
    } stage_t;

    stage_t             st_d, st_q;
    logic [ID_W-1:0]    pick_core;
    hnr_pkg::msg_kind_e pick_kind;

    hnr_dest_pick #(
        .ADDR_W     (ADDR_W),
        .NUM_CORES  (NUM_CORES),
        .LINE_BYTES (LINE_BYTES),
        .PAGE_BYTES (PAGE_BYTES),
        .ID_W       (ID_W)
    ) pick_i (
        .addr    (req_addr),
        .pat_hit (req_pat_hit),
        .core    (pick_core),
        .kind    (pick_kind)
    );

    assign req_ready = !st_q.vld || out_ready;

    always_comb begin
        st_d = st_q;
        if (out_ready) begin
            st_d.vld = 1'b0;
        end
        if (req_valid && req_ready) begin
            st_d.vld  = 1'b1;
            st_d.core = pick_core;
            st_d.kind = pick_kind;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, core: '0, kind: hnr_pkg::MSG_BASE};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_core  = st_q.core;
    assign out_spec  = (st_q.kind == hnr_pkg::MSG_SPEC);

endmodule

// File: rtl/hnr_checks.sv
module hnr_checks #(
    parameter int ADDR_W     = 32,
    parameter int NUM_CORES  = 6,
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int ID_W       = $clog2(NUM_CORES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_pat_hit,
    input logic              out_valid,
    input logic              out_ready,
    input logic [ID_W-1:0]   out_core,
    input logic              out_spec
);

    localparam int LINE_SH = $clog2(LINE_BYTES);
    localparam int PAGE_SH = $clog2(PAGE_BYTES);

    // R2: baseline destination and type
    a_r2_line_home: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_pat_hit) |=>
        (!out_spec && out_core == ID_W'(($past(req_addr) >> LINE_SH) % NUM_CORES)));

    // R3: speculative destination and type
    a_r3_page_home: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_pat_hit) |=>
        (out_spec && out_core == ID_W'(($past(req_addr) >> PAGE_SH) % NUM_CORES)));

    // R4: accepted request is visible after one edge
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> out_valid);

    // R5: stalled output holds and blocks input
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_core) && $stable(out_spec)));

    a_r5_block: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !req_ready);

    // R6: a free consumer never blocks the requester
    a_r6_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> req_ready);

    // R8: destination in range
    a_r8_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_core) < NUM_CORES));

    // R9: no request and a taken message leaves the output empty
    a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid && out_ready) |=> !out_valid);

endmodule

bind hnode_router hnr_checks #(
    .ADDR_W     (ADDR_W),
    .NUM_CORES  (NUM_CORES),
    .LINE_BYTES (LINE_BYTES),
    .PAGE_BYTES (PAGE_BYTES),
    .ID_W       (ID_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_pat_hit (req_pat_hit),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_core    (out_core),
    .out_spec    (out_spec)
);

// File: tb/hnode_router_tb_top.sv
module hnode_router_tb_top;

    localparam int ADDR_W = 32;
    localparam int NC     = 6;
    localparam int LB     = 64;
    localparam int PB     = 4096;
    localparam int ID_W   = $clog2(NC);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_pat_hit = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [ID_W-1:0]   out_core;
    logic              out_spec;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hnode_router #(.ADDR_W(ADDR_W), .NUM_CORES(NC), .LINE_BYTES(LB), .PAGE_BYTES(PB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_pat_hit(req_pat_hit), .out_valid(out_valid),
        .out_ready(out_ready), .out_core(out_core), .out_spec(out_spec)
    );

    function automatic int home_of(input logic [ADDR_W-1:0] a, input bit hit);
        if (hit) return int'((a / PB) % NC);
        return int'((a / LB) % NC);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // present one request at the falling edge, check the result one edge later
    task automatic route_one(input string req, input logic [ADDR_W-1:0] a, input bit hit);
        @(negedge clk);
        req_valid   = 1'b1;
        req_addr    = a;
        req_pat_hit = hit;
        out_ready   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, int'(out_valid), 1);
        check({req, " core"}, int'(out_core), home_of(a, hit));
        check({req, " type"}, int'(out_spec), int'(hit));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", int'(out_valid), 0);
        check("R1 ready after reset", int'(req_ready), 1);
    endtask

    task automatic t_baseline;
        route_one("R2 line 5", 32'h0000_0140, 1'b0);
        route_one("R2 line 6 wraps", 32'h0000_0180, 1'b0);
        route_one("R8 top line", 32'hFFFF_FFC0, 1'b0);
    endtask

    task automatic t_speculative;
        route_one("R3 page 5", 32'h0000_5000, 1'b1);
        route_one("R3 page 6 wraps", 32'h0000_6000, 1'b1);
        route_one("R8 top page", 32'hFFFF_F000, 1'b1);
    endtask

    task automatic t_offsets;
        route_one("R7 line end", 32'h0000_017F, 1'b0);
        route_one("R7 page end", 32'h0000_5FFF, 1'b1);
        route_one("R7 same page other line", 32'h0000_5040, 1'b1);
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        out_ready   = 1'b0;
        req_valid   = 1'b1;
        req_addr    = 32'h0000_0040;
        req_pat_hit = 1'b0;
        @(negedge clk);
        check("R4 stalled valid", int'(out_valid), 1);
        check("R5 ready low", int'(req_ready), 0);
        req_addr    = 32'h0000_3000;
        req_pat_hit = 1'b1;
        @(negedge clk);
        check("R5 held core", int'(out_core), 1);
        check("R5 held type", int'(out_spec), 0);
        check("R5 still blocked", int'(req_ready), 0);
        out_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R5 next core", int'(out_core), 3);
        check("R5 next type", int'(out_spec), 1);
        @(negedge clk);
        check("R9 drained", int'(out_valid), 0);
    endtask

    task automatic t_stream;
        @(negedge clk);
        out_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            req_valid   = 1'b1;
            req_addr    = ADDR_W'(k * 32'h40 + 32'h200);
            req_pat_hit = 1'b0;
            @(negedge clk);
            check("R6 stream ready", int'(req_ready), 1);
            check("R6 stream valid", int'(out_valid), 1);
            check("R6 stream core", int'(out_core), home_of(ADDR_W'(k * 32'h40 + 32'h200), 1'b0));
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R9 idle after stream", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_baseline();
        t_speculative();
        t_offsets();
        t_backpressure();
        t_stream();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule